// File: doc/BRIEF.md
# Multi-Precision Floating-Point Flag Comparator

This unit compares two IEEE 754 values and turns the outcome into a four-bit condition code. Each value can be half, single or double precision. A format selector picks the precision. The operand buses are 64 bits wide, and narrower formats occupy the low bits. A control input can replace the second operand with positive zero.

A request is accepted on any cycle in which `req_valid` is high. The result appears on the next cycle, qualified by `rsp_valid`. The condition code is ordered as {N,Z,C,V}, with N at bit 3.

NaN operands give a fixed unordered code. They can also raise an invalid-operation exception. A signalling NaN always raises it. A quiet NaN raises it only when the strict-NaN control is set. The trap-enable input decides how the exception is reported:
- with the trap disabled, it appears as a one-cycle pulse that sets a cumulative status flag elsewhere;
- with the trap enabled, it appears as a trap request.

Top module: `fp_flag_cmp`

## Requirements
- R1: A request with `req_valid`=1 yields `rsp_valid`=1 with its result on the following cycle. Without a request, `rsp_valid` is 0 on the next cycle, and `inv_flag_set` and `inv_trap` are 0.
- R2: Format code 2'b10 is undefined. Format code 2'b11 is undefined when `half_en`=0. An undefined format gives `fmt_undef`=1, `nzcv`=4'b0000 and no exception, even with NaN operands. Otherwise `fmt_undef`=0.
- R3: When `zero_cmp`=1, the second operand is +0 of the selected width and `opb` has no effect.
- R4: If either operand is a NaN, `nzcv`=4'b0011. A NaN has an all-ones exponent and a nonzero fraction.
- R5: Ordered results set `nzcv` as follows: less than is 4'b1000, equal is 4'b0110, greater than is 4'b0010.
- R6: +0 and -0 compare equal. Subnormals are ordered by value, with no flush to zero. +inf is above every finite value and -inf is below every finite value.
- R7: With `nan_strict`=0, only a signalling NaN raises invalid. A signalling NaN is a NaN whose top fraction bit is 0. Quiet NaNs (top fraction bit 1) give the unordered code with no exception.
- R8: With `nan_strict`=1, any NaN on either operand raises invalid.
- R9: An invalid operation pulses `inv_flag_set` when `inv_trap_en`=0 and `inv_trap` when `inv_trap_en`=1. The two are never high together.
- R10: The format codes are 2'b00 for single (`opa[31:0]`), 2'b01 for double (`opa[63:0]`) and 2'b11 for half (`opa[15:0]`). Bits above the selected width have no effect.
- R11: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Compare request |
| opa | input | 64 | First operand, low-justified |
| opb | input | 64 | Second operand, low-justified |
| fmt | input | 2 | Precision selector |
| zero_cmp | input | 1 | Compare opa against +0 |
| nan_strict | input | 1 | Treat quiet NaNs as invalid too |
| half_en | input | 1 | Half-precision support strap |
| inv_trap_en | input | 1 | Route invalid to trap instead of flag |
| rsp_valid | output | 1 | Result valid |
| nzcv | output | 4 | Condition flags {N,Z,C,V} |
| inv_flag_set | output | 1 | Pulse to set cumulative invalid flag |
| inv_trap | output | 1 | Invalid-operation trap request |
| fmt_undef | output | 1 | Undefined format indication |

## Verification
Every wrong piece of internal state reaches the ports on the cycle after the request that exposed it:
- A mis-sized exponent or quiet-bit mask shows up as the wrong unordered/ordered code, or as a missing or spurious exception, for one specific precision.
- A bad sign-folding key reverses order for negative or mixed-sign pairs.
- A stale pipeline register shows up as a response pulse with no request, or as an exception that outlives its request.

The vectors cover these cases:
- each precision with garbage in its unused upper bits;
- zero-mode requests with a second operand that would change the answer if it were used;
- NaN operands under every combination of the strictness and trap controls.

// File: rtl/fp_flag_cmp.sv
module fp_flag_cmp (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [63:0] opa,
  input  logic [63:0] opb,
  input  logic [1:0]  fmt,
  input  logic        zero_cmp,
  input  logic        nan_strict,
  input  logic        half_en,
  input  logic        inv_trap_en,
  output logic        rsp_valid,
  output logic [3:0]  nzcv,
  output logic        inv_flag_set,
  output logic        inv_trap,
  output logic        fmt_undef
);
  localparam logic [3:0] FL_LT = 4'b1000;
  localparam logic [3:0] FL_EQ = 4'b0110;
  localparam logic [3:0] FL_GT = 4'b0010;
  localparam logic [3:0] FL_UN = 4'b0011;
  localparam logic [63:0] MAG  = {1'b0, {63{1'b1}}};

  logic [63:0] ja, jb, emask, qmask, fmask, ka, kb;
  logic        fmt_ok, a_nan, b_nan, a_snan, b_snan, both_zero, invalid;
  logic [3:0]  flags_d;

  function automatic logic [63:0] order_key(input logic [63:0] x);
    return x[63] ? ~x : {1'b1, x[62:0]};
  endfunction

  always_comb begin
    case (fmt)
      2'b00: begin
        ja    = {opa[31:0], 32'b0};
        jb    = {opb[31:0], 32'b0};
        emask = 64'h7F80_0000_0000_0000;
        qmask = 64'h0040_0000_0000_0000;
      end
      2'b01: begin
        ja    = opa;
        jb    = opb;
        emask = 64'h7FF0_0000_0000_0000;
        qmask = 64'h0008_0000_0000_0000;
      end
      default: begin
        ja    = {opa[15:0], 48'b0};
        jb    = {opb[15:0], 48'b0};
        emask = 64'h7C00_0000_0000_0000;
        qmask = 64'h0200_0000_0000_0000;
      end
    endcase
    if (zero_cmp) jb = 64'b0;
  end

  assign fmt_ok    = (fmt == 2'b00) || (fmt == 2'b01) || (fmt == 2'b11 && half_en);
  assign fmask     = MAG & ~emask;
  assign a_nan     = ((ja & emask) == emask) && ((ja & fmask) != 64'b0);
  assign b_nan     = ((jb & emask) == emask) && ((jb & fmask) != 64'b0);
  assign a_snan    = a_nan && ((ja & qmask) == 64'b0);
  assign b_snan    = b_nan && ((jb & qmask) == 64'b0);
  assign both_zero = (ja[62:0] == 63'b0) && (jb[62:0] == 63'b0);
  assign ka        = order_key(ja);
  assign kb        = order_key(jb);
  assign invalid   = fmt_ok && (a_snan || b_snan || (nan_strict && (a_nan || b_nan)));

  always_comb begin
    if (!fmt_ok)                flags_d = 4'b0000;
    else if (a_nan || b_nan)    flags_d = FL_UN;
    else if (both_zero)         flags_d = FL_EQ;
    else if (ka == kb)          flags_d = FL_EQ;
    else if (ka < kb)           flags_d = FL_LT;
    else                        flags_d = FL_GT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      nzcv         <= 4'b0;
      inv_flag_set <= 1'b0;
      inv_trap     <= 1'b0;
      fmt_undef    <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      inv_flag_set <= req_valid && invalid && !inv_trap_en;
      inv_trap     <= req_valid && invalid && inv_trap_en;
      if (req_valid) begin
        nzcv      <= flags_d;
        fmt_undef <= !fmt_ok;
      end
    end
  end
endmodule

module fp_flag_cmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        inv_trap_en,
  input logic        rsp_valid,
  input logic [3:0]  nzcv,
  input logic        inv_flag_set,
  input logic        inv_trap,
  input logic        fmt_undef
);
  a_r1_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_resp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !inv_flag_set && !inv_trap);
  a_r2_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && fmt_undef |-> nzcv == 4'b0000 && !inv_flag_set && !inv_trap);
  a_r4_v_means_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && nzcv[0] |-> nzcv == 4'b0011);
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !fmt_undef |->
      (nzcv == 4'b1000 || nzcv == 4'b0110 || nzcv == 4'b0010 || nzcv == 4'b0011));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(inv_flag_set && inv_trap));
  a_r9_trap_routing: assert property (@(posedge clk) disable iff (!rst_n)
    inv_trap |-> $past(inv_trap_en));
  a_r9_exc_is_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_flag_set || inv_trap) |-> nzcv == 4'b0011);
endmodule

bind fp_flag_cmp fp_flag_cmp_chk u_chk (.*);

// File: tb/sim_fp_flag_cmp.sv
module sim_fp_flag_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] opa = '0, opb = '0;
  logic [1:0]  fmt = '0;
  logic        zero_cmp = 1'b0, nan_strict = 1'b0, half_en = 1'b1, inv_trap_en = 1'b0;
  logic        rsp_valid, inv_flag_set, inv_trap, fmt_undef;
  logic [3:0]  nzcv;

  int checks = 0;
  int failures = 0;
  logic [6:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  localparam logic [1:0] FS = 2'b00, FD = 2'b01, FH = 2'b11;
  localparam logic [3:0] LT = 4'b1000, EQ = 4'b0110, GT = 4'b0010, UN = 4'b0011, NO = 4'b0000;

  fp_flag_cmp u0 (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic send(input logic [1:0] f, input logic [63:0] a, input logic [63:0] b,
                      input logic z, input logic st, input logic he, input logic te,
                      input logic [3:0] en, input logic ef, input logic et, input logic eu,
                      input string tag);
    @(negedge clk);
    fmt = f; opa = a; opb = b; zero_cmp = z; nan_strict = st; half_en = he; inv_trap_en = te;
    req_valid = 1'b1;
    exp_q.push_back({en, ef, et, eu});
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) check("R1 unexpected response", 7'h7F, 7'h00);
      else check(tag_q.pop_front(), {nzcv, inv_flag_set, inv_trap, fmt_undef}, exp_q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired got=hang expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {rsp_valid, nzcv, inv_flag_set, inv_trap}, 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle no response", {6'b0, rsp_valid}, 7'b0);

    send(FS, 64'h3F80_0000, 64'h4000_0000, 0,0,1,0, LT,0,0,0, "R5 single 1<2");
    send(FS, 64'h4000_0000, 64'h3F80_0000, 0,0,1,0, GT,0,0,0, "R5 single 2>1");
    send(FS, 64'h3F80_0000, 64'h3F80_0000, 0,0,1,0, EQ,0,0,0, "R5 single 1==1");
    send(FS, 64'hC000_0000, 64'h3F80_0000, 0,0,1,0, LT,0,0,0, "R5 single -2<1");
    send(FS, 64'hC000_0000, 64'hBF80_0000, 0,0,1,0, LT,0,0,0, "R5 single -2<-1");
    send(FS, 64'h0000_0000, 64'h8000_0000, 0,0,1,0, EQ,0,0,0, "R6 single +0==-0");
    send(FS, 64'h0000_0001, 64'h0000_0000, 0,0,1,0, GT,0,0,0, "R6 single subnormal>0");
    send(FS, 64'h7F80_0000, 64'h7F7F_FFFF, 0,0,1,0, GT,0,0,0, "R6 single inf>max");
    send(FD, 64'hFFF0_0000_0000_0000, 64'hBFF0_0000_0000_0000, 0,0,1,0, LT,0,0,0, "R6 double -inf<-1");
    send(FD, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0002, 0,0,1,0, LT,0,0,0, "R6 double subnormals");
    send(FD, 64'h7FF8_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0,0,1,0, UN,0,0,0, "R4 R7 double qNaN silent");
    send(FD, 64'h7FF4_0000_0000_0000, 64'h3FF0_0000_0000_0000, 0,0,1,0, UN,1,0,0, "R7 R9 double sNaN flag");
    send(FD, 64'h3FF0_0000_0000_0000, 64'h7FF4_0000_0000_0000, 0,0,1,1, UN,0,1,0, "R7 R9 double sNaN trap");
    send(FS, 64'h7FC0_0000, 64'h3F80_0000, 0,1,1,0, UN,1,0,0, "R8 single qNaN strict flag");
    send(FH, 64'h3C00, 64'h7E00, 0,1,1,1, UN,0,1,0, "R8 half qNaN strict trap");
    send(FH, 64'hDEAD_BEEF_0000_3C00, 64'h1234_0000_0000_4000, 0,0,1,0, LT,0,0,0, "R10 half upper bits ignored");
    send(FS, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0001_3F80_0000, 0,0,1,0, EQ,0,0,0, "R10 single upper bits ignored");
    send(FH, 64'h7D00, 64'h7D00, 0,1,0,0, NO,0,0,1, "R2 half disabled undefined");
    send(2'b10, 64'h7FF4_0000_0000_0000, 64'h0, 0,1,1,1, NO,0,0,1, "R2 code 10 undefined");
    send(FS, 64'hBF80_0000, 64'hFF80_0000, 1,0,1,0, LT,0,0,0, "R3 single -1 vs zero");
    send(FD, 64'h8000_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1,0,1,0, EQ,0,0,0, "R3 R6 double -0 vs zero");
    send(FH, 64'h0001, 64'h7E00, 1,1,1,0, GT,0,0,0, "R3 half subnormal vs zero, opb NaN ignored");
    send(FH, 64'h7C00, 64'h7BFF, 0,0,1,0, GT,0,0,0, "R6 half inf>max");
    send(FH, 64'h8000, 64'h0000, 0,0,1,0, EQ,0,0,0, "R6 half -0==+0");
    send(FS, 64'h7FA0_0000, 64'h0, 1,0,1,1, UN,0,1,0, "R7 single sNaN zero mode trap");
    send(FH, 64'h7D00, 64'h3C00, 0,0,1,0, UN,1,0,0, "R7 half sNaN flag");

    repeat (3) @(negedge clk);
    check("R1 idle after traffic", {4'b0, rsp_valid, inv_flag_set, inv_trap}, 7'b0);
    check("R1 all responses seen", {1'b0, 6'(exp_q.size())}, 7'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule